// File: doc/BRIEF.md
# Instruction Decoder and Next-PC Control

This block sits between instruction fetch and the execute datapath of a 16-bit single-issue RISC core. Each cycle it takes the fetched 16-bit instruction word and the Zero flag. It produces the register-file read and write addresses and the register write enable. It also produces a sign-extended immediate, the ALU function code, the operand and writeback multiplexer selects, the memory read and write strobes, the multiplier select and the address of the next instruction. The decode path is purely combinational. The program counter is the only register, with a synchronous active-high reset.

The top four bits of every instruction select one of sixteen operations. One of those opcodes passes decoding on to a 4-bit function field in the low nibble. Immediate forms name a single register that is both source and destination, with an 8-bit signed constant. Branch forms carry a 12-bit absolute target. A branch is decided from the Zero flag alone, and a taken branch loads the target into the PC. Otherwise the PC steps by two.

Top module: `dec_branch_top`

## Requirements
- R1: `ra_addr` is always bits 11-8 and `rb_addr` is always bits 7-4. `rd_addr` is bits 7-4 for opcodes 0101, 0110, 0111, 1101 and 1110, and bits 11-8 for every other opcode.
- R2: `imm_ext` is bits 7-0 sign-extended to 16 bits, for every instruction.
- R3: For opcode 1101, `alu_fn` equals bits 3-0. Function codes 0000-1100 assert `flags_we`, and all of them assert `reg_we` except 0100 (compare), which leaves `reg_we` low. Codes 1101-1111 leave both low. `opb_sel` is 00 (register) and `wb_sel` is 00 (ALU).
- R4: Opcode 0101 (load) asserts `mem_rd` and `reg_we`, with `wb_sel`=01 (memory), `opb_sel`=10 (zero) and `alu_fn`=0000. Opcode 0110 (store) asserts `mem_wr`, sets `opb_sel`=10 and never asserts `reg_we`.
- R5: Opcode 0000 and the branch opcodes 1001, 1010 and 1011 leave `reg_we`, `flags_we`, `mem_rd`, `mem_wr`, `mul_sel` and `opa_zero` low, with `alu_fn`, `opb_sel` and `wb_sel` all zero.
- R6: With no taken branch and no reset, `pc_q` advances by 2 at each clock edge, wrapping from 16'hFFFE to 16'h0000.
- R7: When `br_taken` is high, `pc_next` is bits 11-0 zero-extended to 16 bits, and `pc_q` takes that value at the next edge.
- R8: `br_taken` is high for opcode 1001 when `zero_flag` is 1, for 1010 when `zero_flag` is 0, always for 1011, and never for other opcodes.
- R9: `rst` sampled high at a clock edge sets `pc_q` to 16'h0000, even when a taken branch is presented in that cycle.
- R10: Bits 3-0 have no effect on any output except `imm_ext`, `pc_next` and `br_taken` target bits, for every opcode other than 1101.
- R11: Opcodes 0001, 0010, 0011 and 0100 give `alu_fn` 0101 (AND), 0000 (ADD), 0001 (SUB) and 0110 (OR) respectively. Each also gives `opb_sel`=01 (immediate), `reg_we`=1 and `flags_we`=1.
- R12: Opcodes 1110 and 1111 assert `mul_sel` and `reg_we` with `wb_sel`=10 (multiplier); 1110 has `opb_sel`=00 and 1111 has `opb_sel`=01. Opcode 1100 asserts `reg_we` with `wb_sel`=11 (Y register).
- R13: Opcode 0111 gives `reg_we`=1, `opb_sel`=10 and `opa_zero`=0. Opcode 1000 gives `reg_we`=1, `opa_zero`=1 and `opb_sel`=01. Both keep `alu_fn`=0000 and `flags_we`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the PC |
| instr | input | 16 | Instruction word to decode |
| zero_flag | input | 1 | Zero flag from the flag register |
| pc_q | output | 16 | Current PC (fetch address) |
| pc_next | output | 16 | PC value loaded at the next edge |
| ra_addr | output | 4 | First register read address |
| rb_addr | output | 4 | Second register read address |
| rd_addr | output | 4 | Register write address |
| reg_we | output | 1 | Register file write enable |
| flags_we | output | 1 | Flag register update enable |
| imm_ext | output | 16 | Sign-extended immediate |
| alu_fn | output | 4 | ALU function code |
| opa_zero | output | 1 | Force ALU operand A to zero |
| opb_sel | output | 2 | Operand B: 00 register, 01 immediate, 10 zero |
| wb_sel | output | 2 | Writeback: 00 ALU, 01 memory, 10 multiplier, 11 Y |
| mem_rd | output | 1 | Data memory read strobe |
| mem_wr | output | 1 | Data memory write strobe |
| mul_sel | output | 1 | Multiplier in use |
| br_taken | output | 1 | Branch decision |

## Verification
The two events that can meet in one cycle are a taken branch and a synchronous reset. The bench presents an unconditional branch while holding reset high, then checks that the PC comes out of that edge at zero and not at the target. A taken branch and the plain PC step are compared on every clock against a behavioural model. That model also follows the step across the 16'hFFFE to 16'h0000 wrap, which a long run of no-ops reaches from reset.

// File: rtl/dec_pkg.sv
package dec_pkg;

  typedef enum logic [3:0] {
    OP_NOP  = 4'h0, OP_ANDI = 4'h1, OP_ADDI = 4'h2, OP_SUBI = 4'h3,
    OP_ORI  = 4'h4, OP_LW   = 4'h5, OP_SW   = 4'h6, OP_MOV  = 4'h7,
    OP_MOVI = 4'h8, OP_BEQ  = 4'h9, OP_BNE  = 4'hA, OP_BA   = 4'hB,
    OP_MOVY = 4'hC, OP_ALU  = 4'hD, OP_MUL  = 4'hE, OP_MULI = 4'hF
  } op_e;

  localparam logic [3:0] FN_ADD = 4'h0;
  localparam logic [3:0] FN_SUB = 4'h1;
  localparam logic [3:0] FN_CMP = 4'h4;
  localparam logic [3:0] FN_AND = 4'h5;
  localparam logic [3:0] FN_OR  = 4'h6;
  localparam logic [3:0] FN_MAX = 4'hC;

  typedef enum logic [1:0] {OPB_REG = 2'b00, OPB_IMM = 2'b01, OPB_ZERO = 2'b10} opb_e;
  typedef enum logic [1:0] {WB_ALU = 2'b00, WB_MEM = 2'b01, WB_MUL = 2'b10, WB_Y = 2'b11} wb_e;

  typedef struct packed {
    logic       reg_we;
    logic       flags_we;
    logic       mem_rd;
    logic       mem_wr;
    logic       mul_sel;
    logic       opa_zero;
    opb_e       opb;
    wb_e        wb;
    logic [3:0] alu_fn;
    logic       dst_hi;
  } ctrl_t;

endpackage

// File: rtl/dec_fields.sv
module dec_fields #(
  parameter int IW   = 16,
  parameter int XLEN = 16,
  parameter int OPW  = 4,
  parameter int RAW  = 4,
  parameter int IMMW = 8,
  parameter int FNW  = 4,
  parameter int TGTW = 12
) (
  input  logic [IW-1:0]   instr,
  output logic [OPW-1:0]  opcode,
  output logic [RAW-1:0]  fld_hi,
  output logic [RAW-1:0]  fld_lo,
  output logic [FNW-1:0]  func,
  output logic [XLEN-1:0] imm_ext,
  output logic [XLEN-1:0] tgt_ext
);
  localparam int OP_LSB = IW - OPW;
  localparam int HI_LSB = OP_LSB - RAW;
  localparam int LO_LSB = HI_LSB - RAW;

  assign opcode = instr[IW-1:OP_LSB];
  assign fld_hi = instr[OP_LSB-1:HI_LSB];
  assign fld_lo = instr[HI_LSB-1:LO_LSB];
  assign func   = instr[FNW-1:0];

  generate
    if (XLEN > IMMW) begin : g_sext
      assign imm_ext = {{(XLEN-IMMW){instr[IMMW-1]}}, instr[IMMW-1:0]};
    end else begin : g_trunc
      assign imm_ext = instr[XLEN-1:0];
    end
    if (XLEN > TGTW) begin : g_zext
      assign tgt_ext = {{(XLEN-TGTW){1'b0}}, instr[TGTW-1:0]};
    end else begin : g_tgt_trunc
      assign tgt_ext = instr[XLEN-1:0];
    end
  endgenerate
endmodule

// File: rtl/dec_ctrl.sv
module dec_ctrl
  import dec_pkg::*;
(
  input  logic [3:0] opcode,
  input  logic [3:0] func,
  output ctrl_t      ctrl
);
  always_comb begin
    ctrl        = '0;
    ctrl.dst_hi = 1'b1;
    case (op_e'(opcode))
      OP_ANDI: begin
        ctrl.reg_we = 1'b1; ctrl.flags_we = 1'b1; ctrl.opb = OPB_IMM; ctrl.alu_fn = FN_AND;
      end
      OP_ADDI: begin
        ctrl.reg_we = 1'b1; ctrl.flags_we = 1'b1; ctrl.opb = OPB_IMM; ctrl.alu_fn = FN_ADD;
      end
      OP_SUBI: begin
        ctrl.reg_we = 1'b1; ctrl.flags_we = 1'b1; ctrl.opb = OPB_IMM; ctrl.alu_fn = FN_SUB;
      end
      OP_ORI: begin
        ctrl.reg_we = 1'b1; ctrl.flags_we = 1'b1; ctrl.opb = OPB_IMM; ctrl.alu_fn = FN_OR;
      end
      OP_LW: begin
        ctrl.dst_hi = 1'b0; ctrl.mem_rd = 1'b1; ctrl.reg_we = 1'b1;
        ctrl.wb = WB_MEM; ctrl.opb = OPB_ZERO; ctrl.alu_fn = FN_ADD;
      end
      OP_SW: begin
        ctrl.dst_hi = 1'b0; ctrl.mem_wr = 1'b1; ctrl.opb = OPB_ZERO; ctrl.alu_fn = FN_ADD;
      end
      OP_MOV: begin
        ctrl.dst_hi = 1'b0; ctrl.reg_we = 1'b1; ctrl.opb = OPB_ZERO; ctrl.alu_fn = FN_ADD;
      end
      OP_MOVI: begin
        ctrl.reg_we = 1'b1; ctrl.opa_zero = 1'b1; ctrl.opb = OPB_IMM; ctrl.alu_fn = FN_ADD;
      end
      OP_MOVY: begin
        ctrl.reg_we = 1'b1; ctrl.wb = WB_Y;
      end
      OP_ALU: begin
        ctrl.dst_hi = 1'b0;
        ctrl.alu_fn = func;
        if (func <= FN_MAX) begin
          ctrl.flags_we = 1'b1;
          ctrl.reg_we   = (func != FN_CMP);
        end
      end
      OP_MUL: begin
        ctrl.dst_hi = 1'b0; ctrl.mul_sel = 1'b1; ctrl.reg_we = 1'b1; ctrl.wb = WB_MUL;
      end
      OP_MULI: begin
        ctrl.mul_sel = 1'b1; ctrl.reg_we = 1'b1; ctrl.wb = WB_MUL; ctrl.opb = OPB_IMM;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/dec_branch.sv
module dec_branch
  import dec_pkg::*;
#(
  parameter int XLEN    = 16,
  parameter int PC_STEP = 2
) (
  input  logic [3:0]      opcode,
  input  logic            zero_flag,
  input  logic [XLEN-1:0] tgt_ext,
  input  logic [XLEN-1:0] pc_cur,
  output logic            taken,
  output logic [XLEN-1:0] pc_nxt
);
  localparam logic [XLEN-1:0] STEP = XLEN'(PC_STEP);

  always_comb begin
    case (op_e'(opcode))
      OP_BEQ:  taken = zero_flag;
      OP_BNE:  taken = ~zero_flag;
      OP_BA:   taken = 1'b1;
      default: taken = 1'b0;
    endcase
  end

  assign pc_nxt = taken ? tgt_ext : (pc_cur + STEP);
endmodule

// File: rtl/dec_branch_top.sv
module dec_branch_top
  import dec_pkg::*;
#(
  parameter int XLEN             = 16,
  parameter int RAW              = 4,
  parameter int IMMW             = 8,
  parameter int TGTW             = 12,
  parameter int PC_STEP          = 2,
  parameter logic [15:0] RESET_PC = 16'h0000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [15:0]     instr,
  input  logic            zero_flag,
  output logic [XLEN-1:0] pc_q,
  output logic [XLEN-1:0] pc_next,
  output logic [RAW-1:0]  ra_addr,
  output logic [RAW-1:0]  rb_addr,
  output logic [RAW-1:0]  rd_addr,
  output logic            reg_we,
  output logic            flags_we,
  output logic [XLEN-1:0] imm_ext,
  output logic [3:0]      alu_fn,
  output logic            opa_zero,
  output logic [1:0]      opb_sel,
  output logic [1:0]      wb_sel,
  output logic            mem_rd,
  output logic            mem_wr,
  output logic            mul_sel,
  output logic            br_taken
);
  localparam int IW  = 16;
  localparam int OPW = 4;
  localparam int FNW = 4;

  logic [OPW-1:0]  opcode;
  logic [RAW-1:0]  fld_hi, fld_lo;
  logic [FNW-1:0]  func;
  logic [XLEN-1:0] tgt_ext;
  ctrl_t           ctrl;

  dec_fields #(
    .IW(IW), .XLEN(XLEN), .OPW(OPW), .RAW(RAW), .IMMW(IMMW), .FNW(FNW), .TGTW(TGTW)
  ) u_fields (
    .instr(instr), .opcode(opcode), .fld_hi(fld_hi), .fld_lo(fld_lo),
    .func(func), .imm_ext(imm_ext), .tgt_ext(tgt_ext)
  );

  dec_ctrl u_ctrl (.opcode(opcode), .func(func), .ctrl(ctrl));

  dec_branch #(.XLEN(XLEN), .PC_STEP(PC_STEP)) u_branch (
    .opcode(opcode), .zero_flag(zero_flag), .tgt_ext(tgt_ext),
    .pc_cur(pc_q), .taken(br_taken), .pc_nxt(pc_next)
  );

  always_ff @(posedge clk) begin
    if (rst) pc_q <= XLEN'(RESET_PC);
    else     pc_q <= pc_next;
  end

  assign ra_addr  = fld_hi;
  assign rb_addr  = fld_lo;
  assign rd_addr  = ctrl.dst_hi ? fld_hi : fld_lo;
  assign reg_we   = ctrl.reg_we;
  assign flags_we = ctrl.flags_we;
  assign alu_fn   = ctrl.alu_fn;
  assign opa_zero = ctrl.opa_zero;
  assign opb_sel  = ctrl.opb;
  assign wb_sel   = ctrl.wb;
  assign mem_rd   = ctrl.mem_rd;
  assign mem_wr   = ctrl.mem_wr;
  assign mul_sel  = ctrl.mul_sel;

  // PC register checks
  a_r9_reset_pc: assert property (@(posedge clk) rst |=> pc_q == XLEN'(RESET_PC));
  a_r6_pc_step: assert property (@(posedge clk) disable iff (rst)
    !br_taken |=> pc_q == $past(pc_q) + XLEN'(PC_STEP));
  a_r7_branch_load: assert property (@(posedge clk) disable iff (rst)
    br_taken |=> pc_q == XLEN'($past(instr[TGTW-1:0])));

  // Control decode checks
  a_r4_store_no_write: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> !reg_we && !mem_rd);
  a_r5_branch_quiet: assert property (@(posedge clk) disable iff (rst)
    br_taken |-> !reg_we && !flags_we && !mem_rd && !mem_wr && !mul_sel);
  a_r3_cmp_flags_only: assert property (@(posedge clk) disable iff (rst)
    (instr[15:12] == 4'hD && instr[3:0] == 4'h4) |-> flags_we && !reg_we);
  a_r8_branch_opcode: assert property (@(posedge clk) disable iff (rst)
    br_taken |-> (instr[15:12] == 4'h9 || instr[15:12] == 4'hA || instr[15:12] == 4'hB));
endmodule

// File: tb/dec_branch_top_tb.sv
module dec_branch_top_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] instr;
  logic        zero_flag;
  logic [15:0] pc_q, pc_next, imm_ext;
  logic [3:0]  ra_addr, rb_addr, rd_addr, alu_fn;
  logic        reg_we, flags_we, opa_zero, mem_rd, mem_wr, mul_sel, br_taken;
  logic [1:0]  opb_sel, wb_sel;

  int n_checks = 0;
  int n_errors = 0;
  logic [15:0] exp_pc;
  bit          pc_known = 0;
  string       pc_tag = "R9";

  always #10 clk = ~clk;

  dec_branch_top u_dut (
    .clk(clk), .rst(rst), .instr(instr), .zero_flag(zero_flag),
    .pc_q(pc_q), .pc_next(pc_next), .ra_addr(ra_addr), .rb_addr(rb_addr),
    .rd_addr(rd_addr), .reg_we(reg_we), .flags_we(flags_we), .imm_ext(imm_ext),
    .alu_fn(alu_fn), .opa_zero(opa_zero), .opb_sel(opb_sel), .wb_sel(wb_sel),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mul_sel(mul_sel), .br_taken(br_taken)
  );

  task automatic chk(input string req, input string what, input logic [15:0] act,
                     input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic string op_tag(input int op);
    case (op)
      1, 2, 3, 4:    return "R11";
      5, 6:          return "R4";
      0, 9, 10, 11:  return "R5";
      12, 14, 15:    return "R12";
      7, 8:          return "R13";
      default:       return "R3";
    endcase
  endfunction

  // One cycle: apply inputs, compare against the behavioural model, clock, update model.
  task automatic step(input logic [15:0] ins, input logic z, input logic r);
    int op, f;
    logic e_we, e_fl, e_rd, e_wr, e_mul, e_opa, e_tk;
    logic [1:0] e_opb, e_wb;
    logic [3:0] e_fn, e_rdst;
    logic [15:0] e_nxt;
    string t;
    instr = ins; zero_flag = z; rst = r;
    #2;
    op = int'(ins[15:12]); f = int'(ins[3:0]);
    {e_we, e_fl, e_rd, e_wr, e_mul, e_opa, e_tk} = '0;
    e_opb = 2'd0; e_wb = 2'd0; e_fn = 4'd0;
    e_rdst = (op == 5 || op == 6 || op == 7 || op == 13 || op == 14) ? ins[7:4] : ins[11:8];
    case (op)
      1:  begin e_we = 1; e_fl = 1; e_opb = 2'd1; e_fn = 4'd5; end
      2:  begin e_we = 1; e_fl = 1; e_opb = 2'd1; e_fn = 4'd0; end
      3:  begin e_we = 1; e_fl = 1; e_opb = 2'd1; e_fn = 4'd1; end
      4:  begin e_we = 1; e_fl = 1; e_opb = 2'd1; e_fn = 4'd6; end
      5:  begin e_rd = 1; e_we = 1; e_wb = 2'd1; e_opb = 2'd2; end
      6:  begin e_wr = 1; e_opb = 2'd2; end
      7:  begin e_we = 1; e_opb = 2'd2; end
      8:  begin e_we = 1; e_opa = 1; e_opb = 2'd1; end
      9:  e_tk = z;
      10: e_tk = !z;
      11: e_tk = 1;
      12: begin e_we = 1; e_wb = 2'd3; end
      13: begin e_fn = ins[3:0]; if (f <= 12) begin e_fl = 1; e_we = (f != 4); end end
      14: begin e_mul = 1; e_we = 1; e_wb = 2'd2; end
      15: begin e_mul = 1; e_we = 1; e_wb = 2'd2; e_opb = 2'd1; end
      default: ;
    endcase
    if (pc_known) begin
      e_nxt = e_tk ? {4'h0, ins[11:0]} : exp_pc + 16'd2;
      chk(pc_tag, "pc_q", pc_q, exp_pc);
      chk(e_tk ? "R7" : "R6", "pc_next", pc_next, e_nxt);
    end
    t = op_tag(op);
    chk("R1", "ra_addr", {12'h0, ra_addr}, {12'h0, ins[11:8]});
    chk("R1", "rb_addr", {12'h0, rb_addr}, {12'h0, ins[7:4]});
    chk("R1", "rd_addr", {12'h0, rd_addr}, {12'h0, e_rdst});
    chk("R2", "imm_ext", imm_ext, {{8{ins[7]}}, ins[7:0]});
    chk("R8", "br_taken", {15'h0, br_taken}, {15'h0, e_tk});
    chk(t, "reg_we", {15'h0, reg_we}, {15'h0, e_we});
    chk(t, "flags_we", {15'h0, flags_we}, {15'h0, e_fl});
    chk(t, "mem_rd", {15'h0, mem_rd}, {15'h0, e_rd});
    chk(t, "mem_wr", {15'h0, mem_wr}, {15'h0, e_wr});
    chk(t, "mul_sel", {15'h0, mul_sel}, {15'h0, e_mul});
    chk(t, "opa_zero", {15'h0, opa_zero}, {15'h0, e_opa});
    chk(t, "opb_sel", {14'h0, opb_sel}, {14'h0, e_opb});
    chk(t, "wb_sel", {14'h0, wb_sel}, {14'h0, e_wb});
    chk(t, "alu_fn", {12'h0, alu_fn}, {12'h0, e_fn});
    @(posedge clk);
    if (r) begin exp_pc = 16'h0; pc_known = 1; pc_tag = "R9"; end
    else if (pc_known) begin
      exp_pc = e_tk ? {4'h0, ins[11:0]} : exp_pc + 16'd2;
      pc_tag = e_tk ? "R7" : "R6";
    end
    @(negedge clk);
  endtask

  function automatic logic [19:0] ctl_sig();
    return {reg_we, flags_we, mem_rd, mem_wr, mul_sel, opa_zero, opb_sel, wb_sel,
            alu_fn, rd_addr, 2'b00};
  endfunction

  initial begin
    logic [19:0] s0;
    logic [11:0] pats [5] = '{12'h000, 12'h5A7, 12'hFFF, 12'h380, 12'hC7F};
    rst = 1'b1; instr = 16'h0; zero_flag = 1'b0;
    @(negedge clk);
    step(16'h0000, 1'b0, 1'b1);
    step(16'h0000, 1'b0, 1'b1);
    chk("R9", "reset pc_q", pc_q, 16'h0000);

    // Every opcode, both Zero values, several operand patterns
    for (int op = 0; op < 16; op++)
      for (int z = 0; z < 2; z++)
        for (int p = 0; p < 5; p++)
          step({op[3:0], pats[p]}, z[0], 1'b0);

    // All function codes under the ALU opcode (R3)
    for (int fc = 0; fc < 16; fc++)
      step({4'hD, 4'h3, 4'h9, fc[3:0]}, fc[0], 1'b0);

    // Function field ignored outside opcode 1101 (R10)
    for (int op = 0; op < 16; op++) begin
      if (op == 13) continue;
      instr = {op[3:0], 8'h6B, 4'h0}; zero_flag = 1'b1; rst = 1'b0; #2;
      s0 = ctl_sig();
      step({op[3:0], 8'h6B, 4'hF}, 1'b1, 1'b0);
      instr = {op[3:0], 8'h6B, 4'hF}; #1;
      chk("R10", "func ignored", s0[19:4], ctl_sig() >> 4);
    end

    // Reset and a taken branch in the same cycle (R9 wins over R7)
    step(16'hB123, 1'b0, 1'b0);
    chk("R7", "branch target loaded", pc_q, 16'h0123);
    step(16'hBABC, 1'b0, 1'b1);
    chk("R9", "reset beats branch", pc_q, 16'h0000);

    // Run to the top of the address space and wrap (R6)
    for (int i = 0; i < 32767; i++) step(16'h0000, 1'b0, 1'b0);
    chk("R6", "pc before wrap", pc_q, 16'hFFFE);
    step(16'h0000, 1'b0, 1'b0);
    chk("R6", "pc wraps", pc_q, 16'h0000);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule